// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a 32-bit physical address. It walks a two-level translation structure that lives in ordinary memory. A requester presents one virtual address together with a flag that says whether the access is a store. The walker then fetches a first-level (directory) word and a second-level (table) word over a simple word-wide memory port. It checks both words. It returns the physical page number, the composed physical address and the page's permission bits, or a fault code.

When a store is translated to a writable page whose modified flag is still clear, the walker writes the second-level word back to memory with that flag set before it reports completion. The root of the structure is taken from a base-address input, which is sampled when a request is accepted. Only one translation is in flight at a time. The memory port holds its request until the memory acknowledges it, so any response latency is accepted.

Top module: `ptw_top`

## Requirements
- R1: While reset is asserted and afterwards with no request, `busy`, `done` and `mem_req` are low.
- R2: The first memory read of a walk is at address `ptbr + 4*vaddr[31:22]`, where `ptbr` is the value sampled when the request is accepted.
- R3: The second memory read is at address `{pde[31:12], 12'h000} + 4*vaddr[21:12]`, where `pde` is the word returned by the first read.
- R4: On success `resp_ppn` equals `pte[31:12]`, `resp_paddr` equals `{pte[31:12], vaddr[11:0]}`, `resp_perm` equals `pte[4:1]` (bit order dirty, execute, write, read) as held after any write-back, and `fault_code` is 0. Entry bits are: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute, bit 4 dirty.
- R5: A first-level word with bit 0 clear ends the walk with `fault_code` 1 and no further memory access.
- R6: A second-level word with bit 0 clear ends the walk with `fault_code` 2 and no memory write.
- R7: A store to a page whose write bit (bit 2) is clear ends with `fault_code` 3 and no memory write.
- R8: A store to a valid, writable page with dirty (bit 4) clear issues exactly one memory write to the second-level address, with data equal to the fetched word OR 0x10, before `done`.
- R9: A load, or a store to a page whose dirty bit is already set, makes no memory write.
- R10: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr` and `mem_we` hold their values in the next cycle, so that any number of wait cycles gives the same result.
- R11: `busy` is high from the cycle after a request is accepted until `done`, and `req_valid` is ignored while `busy` is high.
- R12: `done` is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptbr | input | 32 | Physical base address of the first-level table |
| req_valid | input | 1 | Translation request, taken when idle |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | 1 for a store access, 0 for a load |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| fault_code | output | 2 | 0 none, 1 first-level invalid, 2 second-level invalid, 3 write not permitted |
| resp_ppn | output | 20 | Physical page number |
| resp_paddr | output | 32 | Translated physical address |
| resp_perm | output | 4 | {dirty, execute, write, read} |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 for a memory write |
| mem_addr | output | 32 | Word address for the access |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Memory completes the access at this edge |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |

## Verification
The assertions assume that the memory raises `mem_ack` only while `mem_req` is high and that it returns read data in the same cycle as the acknowledge. They also assume that the requester drives `req_write` and `req_vaddr` stably in the cycle when `req_valid` is sampled. The bench's memory model answers only pending requests, after a chosen number of wait cycles, and it returns zero for words that were never written, which gives invalid entries. Requests are applied on the falling edge for one cycle. A second request is raised on purpose only while a walk is running.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  // Entry bit positions shared by both table levels.
  localparam int ENT_V = 0;
  localparam int ENT_R = 1;
  localparam int ENT_W = 2;
  localparam int ENT_X = 3;
  localparam int ENT_D = 4;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_DIR,
    WS_TBL,
    WS_WB,
    WS_FIN
  } walk_state_e;

  localparam logic [1:0] FLT_NONE = 2'd0;
  localparam logic [1:0] FLT_DIR  = 2'd1;
  localparam logic [1:0] FLT_TBL  = 2'd2;
  localparam logic [1:0] FLT_PROT = 2'd3;
endpackage

// File: rtl/ptw_addr.sv
module ptw_addr #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  localparam int PPN_W = ADDR_W - OFF_W
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [PPN_W-1:0]  vpn,
  input  logic [PPN_W-1:0]  dir_ppn,
  output logic [ADDR_W-1:0] dir_addr,
  output logic [ADDR_W-1:0] tbl_addr
);
  localparam int PAD = ADDR_W - IDX_W - 2;

  logic [IDX_W-1:0] dir_idx;
  logic [IDX_W-1:0] tbl_idx;

  always_comb begin
    dir_idx  = vpn[PPN_W-1 -: IDX_W];
    tbl_idx  = vpn[IDX_W-1:0];
    dir_addr = base + {{PAD{1'b0}}, dir_idx, 2'b00};
    tbl_addr = {dir_ppn, {OFF_W{1'b0}}} + {{PAD{1'b0}}, tbl_idx, 2'b00};
  end
endmodule

// File: rtl/ptw_check.sv
module ptw_check
  import ptw_pkg::*;
(
  input  logic [ENT_D:0] entry,
  input  logic           is_write,
  output logic           valid,
  output logic           perm_ok,
  output logic           need_wb
);
  always_comb begin
    valid   = entry[ENT_V];
    perm_ok = !is_write || entry[ENT_W];
    need_wb = entry[ENT_V] && is_write && entry[ENT_W] && !entry[ENT_D];
  end

  // R7: a write-back is never requested for a page that forbids stores
  always_comb begin
    if (need_wb) begin
      p_wb_needs_perm_r7: assert (perm_ok && valid);
    end
  end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12,
  parameter int IDX_W  = 10,
  localparam int PPN_W = ADDR_W - OFF_W,
  localparam int PERM_W = ENT_D - ENT_R + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ptbr,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic              req_write,
  output logic              busy,
  output logic              done,
  output logic [1:0]        fault_code,
  output logic [PPN_W-1:0]  resp_ppn,
  output logic [ADDR_W-1:0] resp_paddr,
  output logic [PERM_W-1:0] resp_perm,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [ADDR_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [ADDR_W-1:0] mem_rdata
);
  walk_state_e state_q, state_d;

  logic [ADDR_W-1:0] vaddr_q, base_q, pte_q;
  logic [PPN_W-1:0]  dir_ppn_q;
  logic              write_q;
  logic [1:0]        fault_q, fault_d;
  logic              ld_req, ld_dir, ld_pte, ld_fault, set_dirty;

  logic [ADDR_W-1:0] dir_addr, tbl_addr;
  logic              ent_valid, ent_perm_ok, ent_need_wb;

  ptw_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_addr (
    .base     (base_q),
    .vpn      (vaddr_q[ADDR_W-1:OFF_W]),
    .dir_ppn  (dir_ppn_q),
    .dir_addr (dir_addr),
    .tbl_addr (tbl_addr)
  );

  ptw_check u_check (
    .entry    (mem_rdata[ENT_D:0]),
    .is_write (write_q),
    .valid    (ent_valid),
    .perm_ok  (ent_perm_ok),
    .need_wb  (ent_need_wb)
  );

  // Next-state logic
  always_comb begin
    state_d   = state_q;
    fault_d   = fault_q;
    ld_req    = 1'b0;
    ld_dir    = 1'b0;
    ld_pte    = 1'b0;
    ld_fault  = 1'b0;
    set_dirty = 1'b0;
    unique case (state_q)
      WS_IDLE: begin
        if (req_valid) begin
          ld_req   = 1'b1;
          ld_fault = 1'b1;
          fault_d  = FLT_NONE;
          state_d  = WS_DIR;
        end
      end
      WS_DIR: begin
        if (mem_ack) begin
          if (!ent_valid) begin
            ld_fault = 1'b1;
            fault_d  = FLT_DIR;
            state_d  = WS_FIN;
          end else begin
            ld_dir  = 1'b1;
            state_d = WS_TBL;
          end
        end
      end
      WS_TBL: begin
        if (mem_ack) begin
          ld_pte = 1'b1;
          if (!ent_valid) begin
            ld_fault = 1'b1;
            fault_d  = FLT_TBL;
            state_d  = WS_FIN;
          end else if (!ent_perm_ok) begin
            ld_fault = 1'b1;
            fault_d  = FLT_PROT;
            state_d  = WS_FIN;
          end else if (ent_need_wb) begin
            state_d = WS_WB;
          end else begin
            state_d = WS_FIN;
          end
        end
      end
      WS_WB: begin
        if (mem_ack) begin
          set_dirty = 1'b1;
          state_d   = WS_FIN;
        end
      end
      WS_FIN:  state_d = WS_IDLE;
      default: state_d = WS_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= WS_IDLE;
      fault_q <= FLT_NONE;
    end else begin
      state_q <= state_d;
      if (ld_fault) fault_q <= fault_d;
    end
  end

  // Datapath registers with explicit enables
  always_ff @(posedge clk) begin
    if (ld_req) begin
      vaddr_q <= req_vaddr;
      write_q <= req_write;
      base_q  <= ptbr;
    end
    if (ld_dir)    dir_ppn_q <= mem_rdata[ADDR_W-1:OFF_W];
    if (ld_pte)    pte_q     <= mem_rdata;
    else if (set_dirty) pte_q <= mem_wdata;
  end

  // Outputs
  always_comb begin
    busy       = (state_q == WS_DIR) || (state_q == WS_TBL) || (state_q == WS_WB);
    done       = (state_q == WS_FIN);
    mem_req    = busy;
    mem_we     = (state_q == WS_WB);
    mem_addr   = (state_q == WS_DIR) ? dir_addr : tbl_addr;
    mem_wdata  = pte_q | (ADDR_W'(1) << ENT_D);
    fault_code = fault_q;
    resp_ppn   = pte_q[ADDR_W-1:OFF_W];
    resp_paddr = {pte_q[ADDR_W-1:OFF_W], vaddr_q[OFF_W-1:0]};
    resp_perm  = pte_q[ENT_D:ENT_R];
  end

  // Assertions
  p_quiet_when_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  p_busy_to_done_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  p_done_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_wb_marks_dirty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (write_q && mem_wdata[ENT_D] && mem_wdata[ENT_W] && mem_wdata[ENT_V]));
endmodule

// File: tb/tb_ptw_top.sv
`timescale 1ns/1ps
module tb_ptw_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] ptbr;
  logic        req_valid;
  logic [31:0] req_vaddr;
  logic        req_write;
  logic        busy, done;
  logic [1:0]  fault_code;
  logic [19:0] resp_ppn;
  logic [31:0] resp_paddr;
  logic [3:0]  resp_perm;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ptw_top dut (
    .clk(clk), .rst_n(rst_n), .ptbr(ptbr),
    .req_valid(req_valid), .req_vaddr(req_vaddr), .req_write(req_write),
    .busy(busy), .done(done), .fault_code(fault_code),
    .resp_ppn(resp_ppn), .resp_paddr(resp_paddr), .resp_perm(resp_perm),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // Memory model
  logic [31:0] mem_m [logic [31:0]];
  int          lat = 0;
  int          wcnt = 0;
  int          rd_n = 0;
  int          wr_n = 0;
  logic [31:0] rd_log [4];
  logic [31:0] wr_addr_l, wr_data_l;
  int          dbl_done = 0;
  logic        done_prev = 1'b0;

  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (mem_req) begin
      if (wcnt >= lat) begin
        mem_ack = 1'b1;
        wcnt = 0;
        if (mem_we) begin
          mem_m[mem_addr] = mem_wdata;
          wr_addr_l = mem_addr;
          wr_data_l = mem_wdata;
          wr_n++;
        end else begin
          mem_rdata = mem_m.exists(mem_addr) ? mem_m[mem_addr] : 32'h0;
          if (rd_n < 4) rd_log[rd_n] = mem_addr;
          rd_n++;
        end
      end else begin
        wcnt++;
      end
    end
    if (done && done_prev) dbl_done++;
    done_prev = done;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [1:0]  c_fault;
  logic [19:0] c_ppn;
  logic [31:0] c_paddr;
  logic [3:0]  c_perm;
  bit          c_got;

  task automatic walk(input logic [31:0] va, input bit wr, input int l);
    rd_n = 0; wr_n = 0; lat = l; c_got = 0;
    @(negedge clk); req_valid = 1'b1; req_vaddr = va; req_write = wr;
    @(negedge clk); req_valid = 1'b0;
    for (int i = 0; i < 300 && !c_got; i++) begin
      if (done) begin
        c_got = 1; c_fault = fault_code; c_ppn = resp_ppn;
        c_paddr = resp_paddr; c_perm = resp_perm;
      end else @(negedge clk);
    end
    chk("R12 done seen", 32'(c_got), 32'd1);
    @(negedge clk);
    chk("R12 done one cycle", 32'(done), 32'd0);
  endtask

  task automatic t_reset;
    chk("R1 busy in reset", 32'(busy), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    chk("R1 mem_req in reset", 32'(mem_req), 32'd0);
  endtask

  task automatic t_load_walk;
    walk(32'h7192a44c, 1'b0, 0);
    chk("R2 dir read addr", rd_log[0], 32'h10005718);
    chk("R3 tbl read addr", rd_log[1], 32'h123454A8);
    chk("R4 ppn", 32'(c_ppn), 32'h14817);
    chk("R4 paddr", c_paddr, 32'h1481744c);
    chk("R4 perm", 32'(c_perm), 32'h3);
    chk("R4 fault none", 32'(c_fault), 32'd0);
    chk("R9 no write on load", 32'(wr_n), 32'd0);
  endtask

  task automatic t_store_dirty;
    walk(32'h7192a44c, 1'b1, 3);
    chk("R10 reads with wait", 32'(rd_n), 32'd2);
    chk("R8 one write", 32'(wr_n), 32'd1);
    chk("R8 write addr", wr_addr_l, 32'h123454A8);
    chk("R8 write data", wr_data_l, 32'h14817017);
    chk("R4 perm after wb", 32'(c_perm), 32'hB);
    chk("R10 paddr with wait", c_paddr, 32'h1481744c);
  endtask

  task automatic t_store_already_dirty;
    walk(32'h7192a44c, 1'b1, 1);
    chk("R9 no write when dirty", 32'(wr_n), 32'd0);
    chk("R9 fault none", 32'(c_fault), 32'd0);
  endtask

  task automatic t_protect;
    walk(32'h00401000, 1'b1, 0);
    chk("R7 fault code", 32'(c_fault), 32'd3);
    chk("R7 no write", 32'(wr_n), 32'd0);
    chk("R7 entry unchanged", mem_m[32'h20000004], 32'h33333003);
  endtask

  task automatic t_dir_invalid;
    walk(32'h00800000, 1'b0, 2);
    chk("R5 fault code", 32'(c_fault), 32'd1);
    chk("R5 single read", 32'(rd_n), 32'd1);
    chk("R5 dir addr", rd_log[0], 32'h10005008);
  endtask

  task automatic t_tbl_invalid;
    walk(32'h00402000, 1'b1, 0);
    chk("R6 fault code", 32'(c_fault), 32'd2);
    chk("R6 tbl addr", rd_log[1], 32'h20000008);
    chk("R6 no write", 32'(wr_n), 32'd0);
  endtask

  task automatic t_busy_ignore;
    rd_n = 0; wr_n = 0; lat = 4; c_got = 0;
    @(negedge clk); req_valid = 1'b1; req_vaddr = 32'h7192a44c; req_write = 1'b0;
    @(negedge clk); req_valid = 1'b0;
    chk("R11 busy after accept", 32'(busy), 32'd1);
    req_valid = 1'b1; req_vaddr = 32'h00800000; req_write = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    for (int i = 0; i < 300 && !c_got; i++) begin
      if (done) begin
        c_got = 1; c_fault = fault_code; c_ppn = resp_ppn;
        chk("R11 busy low at done", 32'(busy), 32'd0);
      end else begin
        if (!busy) begin
          chk("R11 busy held", 32'(busy), 32'd1);
        end
        @(negedge clk);
      end
    end
    chk("R11 first walk done", 32'(c_got), 32'd1);
    chk("R11 first walk ppn", 32'(c_ppn), 32'h14817);
    chk("R11 first walk ok", 32'(c_fault), 32'd0);
    repeat (6) @(negedge clk);
    chk("R11 stray request ignored", 32'(rd_n), 32'd2);
    chk("R11 idle after", 32'(busy), 32'd0);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_write = 1'b0;
    mem_ack = 1'b0; mem_rdata = '0;
    ptbr = 32'h10005000;
    mem_m[32'h10005718] = 32'h12345001;
    mem_m[32'h123454A8] = 32'h14817007;
    mem_m[32'h10005004] = 32'h20000001;
    mem_m[32'h20000004] = 32'h33333003;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_load_walk;
    t_store_dirty;
    t_store_already_dirty;
    t_protect;
    t_dir_invalid;
    t_tbl_invalid;
    t_busy_ignore;
    chk("R12 no back-to-back done", 32'(dbl_done), 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule